// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked on-chip request port and an external byte-wide asynchronous static RAM. The RAM has a 21-bit address, an 8-bit data bus, an active-low select paired with an active-high select, an active-low write strobe and an active-low output strobe. Each request is a single read or write, offered with a valid/ready handshake. The controller turns each request into a strobe sequence. Every phase of that sequence lasts a whole number of clock cycles, and these counts are derived at elaboration from nanosecond timing figures and the clock period.

After reset the controller holds the RAM deselected for the supply settling time and reports not-ready. After that it accepts one request at a time.

A write selects the RAM and sets up the address. It then lowers the write strobe and drives the data bus for a pulse long enough to meet the data setup time plus the write-to-float time.

A read selects the RAM with the output strobe low for the access time and captures the data bus on the last access cycle. It returns the byte with a one-cycle valid pulse. It then idles for a turnaround gap so that the RAM stops driving the bus before anything else happens.

The data bus is split into an output, an output enable and an input. The pad's tri-state buffer is built from these outside the block.

Top module: `async_sram_ctrl`

## Requirements
- R1: For N_PWR = ceil(T_PWRUP_PS / CLK_PS) cycles after reset release, `req_ready` is 0 and the RAM is deselected (`sram_sel_n`=1, `sram_sel`=0); during reset the same holds.
- R2: While idle, `req_ready` is 1, the RAM is deselected, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0; the two selects always take opposite levels.
- R3: An accepted write (`req_write`=1) selects the RAM with `sram_we_n`=1, `sram_oe_n`=1 and the bus undriven for N_AS cycles. It then holds `sram_we_n`=0 with `sram_dq_oe`=1 and `sram_dq_out` equal to the request byte for N_WP cycles, and then returns to idle.
- R4: `sram_dq_oe` is 1 only while the RAM is selected and `sram_we_n` is 0.
- R5: Every phase count is ceil(ns / clock period) with a minimum of 1. N_WP covers the largest of the write pulse width, the data setup plus write-to-float time, and the write cycle time. With the default 10 ns clock this gives N_AS=1, N_WP=2, N_RD=1, N_TA=1 and N_PWR=10000.
- R6: An accepted read (`req_write`=0) selects the RAM with `sram_oe_n`=0, `sram_we_n`=1 and the bus undriven for N_RD cycles.
- R7: On the clock edge that ends the last read-access cycle, the controller captures `sram_dq_in`. `rsp_valid` is then 1 for exactly the next cycle, with `rsp_rdata` holding the captured byte. `rsp_valid` is 0 at all other times.
- R8: After each read, the controller holds the RAM deselected, the output strobe high, the bus undriven and `req_ready`=0 for N_TA cycles before it becomes ready again.
- R9: A request is accepted only on a cycle with `req_valid`=1 and `req_ready`=1. While the controller is busy, `req_ready` is 0, and the valid, write, address and data inputs have no effect on the strobes, the address or the driven data.
- R10: `sram_addr` equals the accepted request's address and stays unchanged on every cycle that the RAM is selected.
- R11: `sram_oe_n` and `sram_we_n` are never 0 at the same time, so the controller and the RAM never drive the bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (21) | Byte address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W (8) | Captured read byte |
| sram_addr | output | ADDR_W (21) | RAM address |
| sram_sel_n | output | 1 | Active-low RAM select |
| sram_sel | output | 1 | Active-high RAM select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq_out | output | DATA_W (8) | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable of the data pad driver |
| sram_dq_in | input | DATA_W (8) | Data received from the RAM |

## Verification
The assertions assume that reset is released synchronously to the clock. They also assume that the handshake inputs only matter on cycles where `req_ready` is high. This is why the idle, single-drive and hold properties are written only in terms of the controller's own outputs.

The stimulus changes its inputs shortly after each rising edge. It keeps `req_valid` raised with altered payloads while the controller is busy, and drops it before the controller is ready again. This exercises the ignore rule without starting extra transfers.

A behavioural RAM model in the bench answers reads only when the RAM is selected with the output strobe low and the write strobe high. In every other state it returns a decoy byte, so a capture on the wrong cycle shows up as a wrong response.

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
  parameter int ADDR_W        = 21,
  parameter int DATA_W        = 8,
  parameter int CLK_PS        = 10000,
  parameter int T_PWRUP_PS    = 100000000,
  parameter int T_ASU_PS      = 0,
  parameter int T_WP_PS       = 7000,
  parameter int T_SD_PS       = 5500,
  parameter int T_HZWE_PS     = 5000,
  parameter int T_WC_PS       = 10000,
  parameter int T_AA_PS       = 10000,
  parameter int T_ACE_PS      = 10000,
  parameter int T_DOE_PS      = 5000,
  parameter int T_RC_PS       = 10000,
  parameter int T_HZOE_PS     = 5000,
  parameter int T_HZCE_PS     = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_sel_n,
  output logic              sram_sel,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int cycles_for(input int ps);
    int n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int N_PWR = cycles_for(T_PWRUP_PS);
  localparam int N_AS  = cycles_for(T_ASU_PS);
  localparam int N_WP  = cycles_for(max3(T_WP_PS, T_SD_PS + T_HZWE_PS, T_WC_PS));
  localparam int N_RD  = cycles_for(max3(max3(T_AA_PS, T_ACE_PS, T_DOE_PS), T_RC_PS, 0));
  localparam int N_TA  = cycles_for(max3(T_HZOE_PS, T_HZCE_PS, 0));
  localparam int N_MAX = max3(max3(N_PWR, N_AS, N_WP), N_RD, N_TA);
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_IDLE, ST_WSETUP, ST_WPULSE, ST_RACC, ST_TURN
  } phase_t;

  phase_t            st;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;
  logic              last;
  logic              selected;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      cnt     <= CW'(N_PWR - 1);
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        ST_PWR: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (req_write) begin
              st  <= ST_WSETUP;
              cnt <= CW'(N_AS - 1);
            end else begin
              st  <= ST_RACC;
              cnt <= CW'(N_RD - 1);
            end
          end
        end
        ST_WSETUP: begin
          if (last) begin
            st  <= ST_WPULSE;
            cnt <= CW'(N_WP - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WPULSE: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        ST_RACC: begin
          if (last) begin
            rdata_q <= sram_dq_in;
            rsp_q   <= 1'b1;
            st      <= ST_TURN;
            cnt     <= CW'(N_TA - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_TURN: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign selected    = (st == ST_WSETUP) || (st == ST_WPULSE) || (st == ST_RACC);
  assign sram_sel_n  = !selected;
  assign sram_sel    = selected;
  assign sram_we_n   = (st != ST_WPULSE);
  assign sram_oe_n   = (st != ST_RACC);
  assign sram_dq_oe  = (st == ST_WPULSE);
  assign sram_dq_out = wdata_q;
  assign sram_addr   = addr_q;
  assign req_ready   = (st == ST_IDLE);
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_sel_n,
  input logic              sram_sel,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe
);

  p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sram_sel_n == !sram_sel);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_sel_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_drive_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_sel_n && sram_sel && !sram_we_n));

  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!sram_oe_n));

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sram_oe_n) && sram_oe_n) |-> (sram_sel_n && !req_ready && !sram_dq_oe));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_sel_n |-> !req_ready);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_sel_n && $past(!sram_sel_n)) |-> $stable(sram_addr));

  p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_sel_n (sram_sel_n),
  .sram_sel   (sram_sel),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_async_sram_ctrl.sv
module test_async_sram_ctrl;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int CLK_PS = 10000;

  function automatic int ceil_cyc(input int ps);
    int n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    if (n < 1) n = 1;
    return n;
  endfunction

  // R5: counts computed from the timing figures, independent of the design
  localparam int E_PWR = ceil_cyc(100000000);
  localparam int E_AS  = ceil_cyc(0);
  localparam int E_WP  = ceil_cyc(5500 + 5000);
  localparam int E_RD  = ceil_cyc(10000);
  localparam int E_TA  = ceil_cyc(5000);

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_sel_n, sram_sel, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in = 8'hEE;

  always #5 clk = ~clk;

  async_sram_ctrl i_async_sram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_sel_n(sram_sel_n), .sram_sel(sram_sel),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // behavioural RAM
  logic [7:0] sram [int];
  logic [7:0] refm [int];

  function automatic logic [7:0] fill(input int a);
    return a[7:0] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    #2;
    if (!sram_sel_n && sram_sel && !sram_oe_n && sram_we_n)
      sram_dq_in = sram.exists(int'(sram_addr)) ? sram[int'(sram_addr)] : fill(int'(sram_addr));
    else
      sram_dq_in = 8'hEE;
  end

  always @(negedge clk) begin
    if (rst_n && !sram_sel_n && sram_sel && !sram_we_n && sram_dq_oe)
      sram[int'(sram_addr)] = sram_dq_out;
  end

  // reference model: 0 idle, 1 write setup, 2 write pulse, 3 read access, 4 turnaround
  bit model_on = 0;
  int pwr_left;
  int kq[$];
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  bit exp_rsp = 0;
  logic [DW-1:0] exp_rdata;

  always @(negedge clk) begin
    if (model_on) begin
      int k;
      bit ex_sel, ex_we_n, ex_oe_n, ex_oe, ex_rdy, nxt_rsp;
      k = (pwr_left > 0 || kq.size() == 0) ? 0 : kq[0];
      ex_sel  = (k == 1) || (k == 2) || (k == 3);
      ex_we_n = (k != 2);
      ex_oe_n = (k != 3);
      ex_oe   = (k == 2);
      ex_rdy  = (pwr_left == 0) && (kq.size() == 0);
      check(req_ready == ex_rdy, (pwr_left > 0) ? "R1 ready" : "R9 ready", req_ready, ex_rdy);
      check(sram_sel_n == !ex_sel && sram_sel == ex_sel, "R2/R3/R6 selects",
            {sram_sel_n, sram_sel}, {!ex_sel, ex_sel});
      check(sram_we_n == ex_we_n, "R3 write strobe", sram_we_n, ex_we_n);
      check(sram_oe_n == ex_oe_n, (k == 4) ? "R8 output strobe" : "R6 output strobe", sram_oe_n, ex_oe_n);
      check(sram_dq_oe == ex_oe, "R4 bus drive", sram_dq_oe, ex_oe);
      if (k == 2) check(sram_dq_out == cur_wdata, "R3 write data", sram_dq_out, cur_wdata);
      if (ex_sel) check(sram_addr == cur_addr, "R10 address", sram_addr, cur_addr);
      check(rsp_valid == exp_rsp, "R7 response valid", rsp_valid, exp_rsp);
      if (exp_rsp) check(rsp_rdata == exp_rdata, "R7 read data", rsp_rdata, exp_rdata);
      check(!(!sram_oe_n && !sram_we_n), "R11 contention", {sram_oe_n, sram_we_n}, 2'b11);
      nxt_rsp = 0;
      if (pwr_left > 0) pwr_left--;
      else if (kq.size() > 0) begin
        int p;
        p = kq.pop_front();
        if (p == 3 && (kq.size() == 0 || kq[0] != 3)) nxt_rsp = 1;
      end else if (req_valid) begin
        cur_addr  = req_addr;
        cur_wdata = req_wdata;
        if (req_write) begin
          refm[int'(req_addr)] = req_wdata;
          for (int i = 0; i < E_AS; i++) kq.push_back(1);
          for (int i = 0; i < E_WP; i++) kq.push_back(2);
        end else begin
          exp_rdata = refm.exists(int'(req_addr)) ? refm[int'(req_addr)] : fill(int'(req_addr));
          for (int i = 0; i < E_RD; i++) kq.push_back(3);
          for (int i = 0; i < E_TA; i++) kq.push_back(4);
        end
      end
      exp_rsp = nxt_rsp;
    end
  end

  task automatic send(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input int junk);
    bit acc;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    // R9: altered payload while busy must have no effect
    for (int j = 0; j < junk; j++) begin
      req_write = !w; req_addr = ~a; req_wdata = ~d;
      @(posedge clk); #1;
    end
    req_valid = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 0, "R1 ready in reset", req_ready, 0);
    check(sram_sel_n == 1 && sram_sel == 0, "R1 deselected in reset", {sram_sel_n, sram_sel}, 2'b10);
    check(sram_dq_oe == 0, "R4 undriven in reset", sram_dq_oe, 0);
    @(posedge clk); #1;
    rst_n = 1;
    pwr_left = E_PWR;
    model_on = 1;
    send(1, 21'h000000, 8'h11, 0);
    send(1, 21'h1FFFFF, 8'hEE, 0);
    send(0, 21'h000000, 8'h00, 0);
    send(0, 21'h1FFFFF, 8'h00, 0);
    send(0, 21'h000ABC, 8'h00, 0);
    gap(3);
    send(0, 21'h000005, 8'h00, 0);
    send(1, 21'h000005, 8'h5A, 0);
    send(0, 21'h000005, 8'h00, 0);
    send(1, 21'h000009, 8'h99, 2);
    send(0, 21'h000009, 8'h00, 0);
    for (int i = 0; i < 12; i++) begin
      send(1, AW'(i * 40503 + 7), DW'(i * 29 + 3), (i % 2 == 0) ? 2 : 0);
      if (i % 3 == 0) gap(2);
    end
    for (int i = 11; i >= 0; i--) send(0, AW'(i * 40503 + 7), 8'h00, 0);
    gap(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule